// File: doc/BRIEF.md
# UART Automatic Modem-Line Flow Control

This block runs automatic hardware handshaking for one UART channel. On the receive side it compares the receive FIFO fill level against two programmable thresholds. It raises an active-low "request" output to stop the remote sender when the FIFO gets full. It lowers the output again only once the FIFO has drained to the lower threshold, so the line does not chatter. On the transmit side it watches the partner's active-low "clear" input. From that input it drives a transmit-enable that the local serializer obeys. The enable changes only at character boundaries, so a character already on the wire is always completed.

A 3-bit flow mode field turns the function on, and a 3-bit pin mode field selects which pin pair carries the handshake. One setting uses the RTS/CTS pair. The other moves the handshake onto the DTR/DSR lines, which take over two general-purpose pins: general pin 3 becomes the request output and general pin 2 becomes the clear input. Both pin inputs pass through a two-flop synchronizer before use.

Top module: `uart_autoflow`

## Requirements
- R1: Flow control is active only when `flow_mode_i` equals 3'b001. For any other value, `rts_n_o` is low and `tx_en_o` is high.
- R2: While flow control is active, a FIFO level greater than or equal to `hi_thresh_i` sets the stop state on the clock edge that samples it. The request line then reads high from that edge onward.
- R3: The stop state clears only on an edge where the level is less than or equal to `lo_thresh_i`. A level strictly between the thresholds leaves it unchanged. If both threshold tests are true at once, the high-threshold test wins.
- R4: While flow control is active, a high (deasserted) clear input suspends transmission. `tx_en_o` falls only on an edge where `tx_boundary_i` is high, so a character in progress is never cut short.
- R5: A low clear input re-enables transmission. `tx_en_o` rises on an edge where `tx_boundary_i` is high.
- R6: Each clear pin passes two synchronizer flops that reset to 1, so a pin change can reach `tx_en_o` no earlier than the third rising edge after it.
- R7: When `pin_mode_i` equals 3'b010, the stop state drives `gp3_dtr_n_o`, `rts_n_o` is held low, and the clear input is taken from `gp2_dsr_n_i`. In this mode `cts_n_i` has no effect.
- R8: For any other `pin_mode_i` value, the stop state drives `rts_n_o`, the clear input is `cts_n_i`, `gp2_dsr_n_i` has no effect, and `gp3_dtr_n_o` follows `gp3_val_i`.
- R9: While reset is asserted and directly after it, the stop state is clear and `tx_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_mode_i | input | 3 | Flow mode field; 3'b001 enables hardware flow control |
| pin_mode_i | input | 3 | Pin mode field; 3'b010 moves the handshake to general pins 3/2 |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| hi_thresh_i | input | LVL_W | Level at which the request output stops the partner |
| lo_thresh_i | input | LVL_W | Level at which the request output releases the partner |
| tx_boundary_i | input | 1 | High when the serializer is between characters |
| cts_n_i | input | 1 | Partner clear input, active low (asynchronous) |
| gp2_dsr_n_i | input | 1 | General pin 2, used as the alternate clear input (asynchronous) |
| gp3_val_i | input | 1 | General-purpose value for pin 3 when it is not used for handshaking |
| rts_n_o | output | 1 | Request output, active low |
| gp3_dtr_n_o | output | 1 | General pin 3 drive: the alternate request, or `gp3_val_i` |
| tx_en_o | output | 1 | Transmit enable to the serializer |

## Verification
A change in FIFO level is reflected on the request pin at the first rising edge, so it is due at the following falling edge. Pin-mode and pin-3 value changes reach the outputs combinationally within the same cycle. A clear-pin change needs three rising edges before it can reach `tx_en_o`, and it needs a further boundary-high edge if the boundary input is low. The bench drives inputs just after each falling edge and checks at the next falling edge against a behavioural model that delays the pins by two edges in a queue. The directed checks count those exact edges: an R6 check confirms that nothing has moved after two edges, and the R4 or R5 check follows on the third edge.

// File: rtl/uart_autoflow_pkg.sv
package uart_autoflow_pkg;
  localparam logic [2:0] FLOW_MODE_HW = 3'b001;
  localparam logic [2:0] PIN_MODE_ALT = 3'b010;

  typedef struct packed {
    logic hw_en;
    logic alt_pins;
  } flow_cfg_t;

  function automatic flow_cfg_t decode_cfg(logic [2:0] flow_mode, logic [2:0] pin_mode);
    flow_cfg_t c;
    c.hw_en    = (flow_mode == FLOW_MODE_HW);
    c.alt_pins = (pin_mode == PIN_MODE_ALT);
    return c;
  endfunction
endpackage

// File: rtl/uaf_sync.sv
module uaf_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {(STAGES*WIDTH){RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  initial begin
    assert_stages_R6: assert (STAGES >= 2);
  end
endmodule

// File: rtl/uaf_rx_hyst.sv
module uaf_rx_hyst #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] hi_i,
  input  logic [LVL_W-1:0] lo_i,
  output logic             stop_o
);
  logic stop_q;
  logic at_hi, at_lo;

  assign at_hi = (level_i >= hi_i);
  assign at_lo = (level_i <= lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stop_q <= 1'b0;
    else if (!en_i)  stop_q <= 1'b0;
    else if (at_hi)  stop_q <= 1'b1;   // high threshold has priority
    else if (at_lo)  stop_q <= 1'b0;
  end

  assign stop_o = stop_q;

  assert_stop_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_q) |-> $past(en_i && level_i >= hi_i));
  assert_stop_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && level_i >= hi_i) |=> stop_q);
  assert_stop_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_q) |-> $past(!en_i || (level_i <= lo_i && level_i < hi_i)));
  assert_stop_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && level_i > lo_i && level_i < hi_i) |=> $stable(stop_q));
endmodule

// File: rtl/uaf_tx_gate.sv
module uaf_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clear_n_i,
  input  logic boundary_i,
  output logic tx_en_o
);
  logic go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         go_q <= 1'b1;
    else if (!en_i)      go_q <= 1'b1;
    else if (boundary_i) go_q <= !clear_n_i;
  end

  assign tx_en_o = !en_i || go_q;

  assert_txen_mid_char_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !boundary_i) |=> $stable(go_q));
  assert_txen_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(go_q) |-> $past(en_i && boundary_i && clear_n_i));
  assert_txen_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_q) |-> $past(!en_i || (boundary_i && !clear_n_i)));
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_autoflow_pkg::*;
#(
  parameter int unsigned LVL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       flow_mode_i,
  input  logic [2:0]       pin_mode_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] hi_thresh_i,
  input  logic [LVL_W-1:0] lo_thresh_i,
  input  logic             tx_boundary_i,
  input  logic             cts_n_i,
  input  logic             gp2_dsr_n_i,
  input  logic             gp3_val_i,
  output logic             rts_n_o,
  output logic             gp3_dtr_n_o,
  output logic             tx_en_o
);
  localparam int unsigned NPINS = 2;
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;

  flow_cfg_t        cfg;
  logic [NPINS-1:0] pins_raw, pins_s;
  logic             stop, clear_n;

  assign cfg      = decode_cfg(flow_mode_i, pin_mode_i);
  assign pins_raw = {gp2_dsr_n_i, cts_n_i};

  uaf_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  assign clear_n = cfg.alt_pins ? pins_s[IDX_DSR] : pins_s[IDX_CTS];

  uaf_rx_hyst #(.LVL_W(LVL_W)) u_rx_hyst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg.hw_en),
    .level_i(rx_level_i),
    .hi_i   (hi_thresh_i),
    .lo_i   (lo_thresh_i),
    .stop_o (stop)
  );

  uaf_tx_gate u_tx_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg.hw_en),
    .clear_n_i (clear_n),
    .boundary_i(tx_boundary_i),
    .tx_en_o   (tx_en_o)
  );

  assign rts_n_o     = stop && !cfg.alt_pins;
  assign gp3_dtr_n_o = cfg.alt_pins ? stop : gp3_val_i;

  assert_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_mode_i != FLOW_MODE_HW) |=> ((flow_mode_i != FLOW_MODE_HW) -> (!rts_n_o && tx_en_o)));
  assert_alt_rts_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode_i == PIN_MODE_ALT) |-> !rts_n_o);
  assert_gp3_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode_i != PIN_MODE_ALT) |-> (gp3_dtr_n_o == gp3_val_i));
endmodule

// File: tb/uart_autoflow_tb.sv
module uart_autoflow_tb;
  localparam int LVL_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       flow_mode = 3'b000, pin_mode = 3'b000;
  logic [LVL_W-1:0] level = '0, hi = 8'd96, lo = 8'd32;
  logic             boundary = 1'b1, cts_n = 1'b1, dsr_n = 1'b1, gp3_val = 1'b0;
  logic             rts_n, gp3_o, tx_en;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_autoflow #(.LVL_W(LVL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flow_mode_i(flow_mode), .pin_mode_i(pin_mode),
    .rx_level_i(level), .hi_thresh_i(hi), .lo_thresh_i(lo), .tx_boundary_i(boundary),
    .cts_n_i(cts_n), .gp2_dsr_n_i(dsr_n), .gp3_val_i(gp3_val),
    .rts_n_o(rts_n), .gp3_dtr_n_o(gp3_o), .tx_en_o(tx_en)
  );

  // behavioural reference
  bit m_stop, m_go;
  bit cq[$], dq[$];

  task automatic model_reset();
    m_stop = 0; m_go = 1;
    cq = '{1, 1}; dq = '{1, 1};
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      bit en, alt, clr;
      en  = (flow_mode == 3'd1);
      alt = (pin_mode == 3'd2);
      clr = alt ? dq[0] : cq[0];          // value presented after two edges
      if (!en) m_stop = 0;
      else if (int'(level) >= int'(hi)) m_stop = 1;
      else if (int'(level) <= int'(lo)) m_stop = 0;
      if (!en) m_go = 1;
      else if (boundary) m_go = !clr;
      void'(cq.pop_front()); cq.push_back(cts_n);
      void'(dq.pop_front()); dq.push_back(dsr_n);
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit en, alt;
      en  = (flow_mode == 3'd1);
      alt = (pin_mode == 3'd2);
      chk("R3 rts_n_o", rts_n, m_stop && !alt);
      chk("R7 gp3_dtr_n_o", gp3_o, alt ? m_stop : gp3_val);
      chk("R4 tx_en_o", tx_en, !en || m_go);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      finish_run();
    end
  end

  initial begin
    // R9 reset state
    #1;
    chk("R9 rts in reset", rts_n, 1'b0);
    chk("R9 tx_en in reset", tx_en, 1'b1);
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R9 rts after reset", rts_n, 1'b0);
    chk("R9 tx_en after reset", tx_en, 1'b1);

    // R1 disabled: full FIFO and blocked partner have no effect
    flow_mode = 3'b101; level = 8'd200; cts_n = 1'b1;
    repeat (5) tick();
    chk("R1 rts low when disabled", rts_n, 1'b0);
    chk("R1 tx_en high when disabled", tx_en, 1'b1);

    // R2/R3 hysteresis
    flow_mode = 3'b001; cts_n = 1'b0; level = 8'd95;
    repeat (4) tick();
    chk("R2 below hi stays go", rts_n, 1'b0);
    level = 8'd96;
    @(negedge clk); chk("R2 at hi stops", rts_n, 1'b1); #1;
    level = 8'd50; repeat (3) tick();
    chk("R3 mid band holds stop", rts_n, 1'b1);
    level = 8'd33; tick();
    chk("R3 above lo holds stop", rts_n, 1'b1);
    level = 8'd32;
    @(negedge clk); chk("R3 at lo releases", rts_n, 1'b0); #1;
    level = 8'd90; tick();
    chk("R3 mid band holds go", rts_n, 1'b0);
    for (int i = 0; i < 64; i++) begin level = LVL_W'(i * 4); tick(); end
    for (int i = 63; i >= 0; i--) begin level = LVL_W'(i * 4); tick(); end

    // R4/R6 suspend at boundary only
    level = 8'd0; cts_n = 1'b0; boundary = 1'b1; repeat (4) tick();
    boundary = 1'b0; cts_n = 1'b1;
    repeat (10) tick();
    chk("R4 no suspend mid character", tx_en, 1'b1);
    boundary = 1'b1;
    @(negedge clk); chk("R4 suspend at boundary", tx_en, 1'b0); #1;
    // R5/R6 resume after sync delay
    cts_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 no change after two edges", tx_en, 1'b0);
    @(negedge clk); chk("R5 resume on third edge", tx_en, 1'b1); #1;
    cts_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 still enabled after two edges", tx_en, 1'b1);
    @(negedge clk); chk("R4 suspend on third edge", tx_en, 1'b0); #1;

    // R7 alternate pins
    cts_n = 1'b0; dsr_n = 1'b0; pin_mode = 3'b010; gp3_val = 1'b1;
    repeat (4) tick();
    chk("R7 dsr clears", tx_en, 1'b1);
    cts_n = 1'b1; repeat (6) tick();
    chk("R7 cts ignored", tx_en, 1'b1);
    level = 8'd120; tick();
    chk("R7 dtr stops", gp3_o, 1'b1);
    chk("R7 rts held low", rts_n, 1'b0);
    dsr_n = 1'b1; repeat (4) tick();
    chk("R7 dsr suspends", tx_en, 1'b0);

    // R8 standard pins: dsr ignored, gp3 pass-through
    pin_mode = 3'b000; cts_n = 1'b0; dsr_n = 1'b0; repeat (4) tick();
    dsr_n = 1'b1; repeat (6) tick();
    chk("R8 dsr ignored", tx_en, 1'b1);
    gp3_val = 1'b0; #0.5;
    chk("R8 gp3 follows value", gp3_o, 1'b0);
    chk("R8 rts carries stop", rts_n, 1'b1);
    level = 8'd0; tick();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      level    = LVL_W'($urandom_range(0, 255));
      boundary = r[0] | r[1];
      if (r[4:2] == 0) cts_n = ~cts_n;
      if (r[7:5] == 0) dsr_n = ~dsr_n;
      if (r[11:8] == 0) pin_mode = r[12] ? 3'b010 : 3'(r[15:13]);
      if (r[19:16] == 0) flow_mode = r[20] ? 3'b001 : 3'(r[23:21]);
      if (r[26:24] == 0) gp3_val = ~gp3_val;
      if (r[31:27] == 0) begin hi = LVL_W'($urandom_range(0, 255)); lo = LVL_W'($urandom_range(0, 255)); end
      tick();
    end
    finish_run();
  end
endmodule